// File: doc/BRIEF.md
# ADC Result Post-Processing Engine

This block sits behind an analog-to-digital converter and refines its stream of results. Each conversion delivers one unsigned sample with a trigger pulse. Depending on a 3-bit mode select, the block passes the sample through unchanged or folds it into a running computation: a free-running sum, a windowed average, a burst average gathered on consecutive cycles, or a first-order recursive low-pass filter. The window length is a power of two, set as an exponent `rpt_log2`, so N = 2^rpt_log2.

When a computation completes, the block forms a signed error from the newest raw result or filtered value, measured against either a setpoint or a remembered previous value. It then classifies that error against a lower and an upper threshold. Two sticky flags report progress to the surrounding logic. One marks a finished conversion and the other marks a threshold hit. Both are cleared by `flag_clr`, and a new event arriving in the same cycle as the clear wins over it.

Samples update `result`, `acc`, `cnt` and `filt` one cycle after the trigger edge. The error, the remembered previous value and both flags update one cycle after that.

Top module: `adcpp_engine`

## Requirements
- R1: Basic mode (`mode` 000, and the unused codes 101 to 111): every trigger loads `result` and sets `filt` equal to the sample. With `dbl_en`=0 every trigger counts as a finished conversion and is tested. With `dbl_en`=1 only every second trigger after reset counts and is tested.
- R2: Accumulate mode (001): every trigger adds the sample to `acc` and increments `cnt`, which saturates at its all-ones value. `filt` becomes min(`acc` >> rpt_log2, sample full scale). Every trigger is tested.
- R3: Average mode (010): triggers add to `acc` and increment `cnt`. The trigger that brings `cnt` to N sets `filt` to `acc` >> rpt_log2 and is tested.
- R4: Average mode: the first trigger after a tested one loads `acc` with its own sample and sets `cnt` to 1, rather than adding to the old total.
- R5: Burst mode (011): a trigger while `busy` is low loads `acc` with the sample and sets `cnt` to 1. It then takes the `sample` input on each following cycle, with `busy` high, until `cnt` reaches N. That last sample sets `filt` = `acc` >> rpt_log2 and is tested. Triggers while `busy` is high have no effect.
- R6: Low-pass mode (100): every trigger applies filt += (sample − filt) >>> rpt_log2, using an arithmetic, flooring shift. `cnt` counts up to N and holds there. Every trigger from the Nth onward is tested.
- R7: A test sets `err` from `calc_sel`. Bit 0 picks the minuend: 0 gives `result`, 1 gives `filt`. Bit 1 picks the subtrahend: 0 gives the previous value, 1 gives `setpoint`. Bit 2 negates the difference.
- R8: After each test, the previous value is updated to `filt` when `prev_sel`=1, or to `result` when `prev_sel`=0. It resets to 0.
- R9: A test sets `thr_flag` according to `thr_mode`, with signed compares: 000 never, 001 err<lo, 010 err≥lo, 011 lo≤err≤hi, 100 err<lo or err>hi, 101 err≤hi, 110 err>hi, 111 always.
- R10: `conv_flag` is set by every counted conversion and `thr_flag` by every threshold hit. Both hold until `flag_clr` is applied, and a set in the same cycle overrides the clear.
- R11: `acc` saturates at all ones and never wraps.
- R12: Synchronous reset clears `result`, `acc`, `cnt`, `filt`, `err`, `busy`, both flags and the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | A new sample is present |
| sample | input | SW | Unsigned conversion result |
| mode | input | 3 | Processing mode select |
| rpt_log2 | input | LOGW | Window exponent, N = 2^rpt_log2 |
| dbl_en | input | 1 | Pairs triggers in basic mode |
| calc_sel | input | 3 | Error formation select |
| prev_sel | input | 1 | Previous value source: 1 filtered, 0 raw |
| setpoint | input | SW | Unsigned setpoint |
| thr_lo | input | SW+2 | Signed lower threshold |
| thr_hi | input | SW+2 | Signed upper threshold |
| thr_mode | input | 3 | Threshold outcome select |
| flag_clr | input | 1 | Clears both sticky flags |
| result | output | SW | Latest raw sample |
| acc | output | SW+LOG_MAX+1 | Accumulator |
| cnt | output | LOG_MAX+1 | Sample counter |
| filt | output | SW | Averaged or filtered value |
| err | output | SW+2 | Signed error from the last test |
| busy | output | 1 | Burst collection in progress |
| conv_flag | output | 1 | Sticky conversion-done flag |
| thr_flag | output | 1 | Sticky threshold flag |

## Verification
The bench targets the average-mode reseed after a test. A design that kept adding there would double-count the previous window and set `cnt` past N. It drives triggers into an ongoing burst: a design that restarted would reset `cnt` to 1 and never finish. It runs full-scale samples long enough in accumulate mode to reach the saturation point, where a wrapping adder would drop `acc` toward zero. Finally, it makes flag clears collide with new events, where a clear-priority design would lose a hit. The low-pass step for falling inputs relies on flooring shifts, so a logical shift would send `filt` far above the sample.

// File: rtl/adcpp_pkg.sv
package adcpp_pkg;

    typedef enum logic [2:0] {
        MD_BASIC = 3'd0,
        MD_ACCUM = 3'd1,
        MD_AVG   = 3'd2,
        MD_BURST = 3'd3,
        MD_LPF   = 3'd4
    } mode_e;

    typedef struct packed {
        logic conv;   // a counted conversion finished
        logic test;   // a threshold evaluation is due
    } evt_t;

    // Outcome of the threshold test from the two signed comparisons.
    function automatic logic thr_hit(input logic [2:0] tm,
                                     input logic below, input logic above);
        case (tm)
            3'd0:    thr_hit = 1'b0;
            3'd1:    thr_hit = below;
            3'd2:    thr_hit = !below;
            3'd3:    thr_hit = !below && !above;
            3'd4:    thr_hit = below || above;
            3'd5:    thr_hit = !above;
            3'd6:    thr_hit = above;
            default: thr_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/adcpp_core.sv
module adcpp_core
    import adcpp_pkg::*;
#(
    parameter int SW      = 10,
    parameter int LOG_MAX = 7,
    parameter int LOGW    = 3,
    parameter int ACC_W   = 18,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [SW-1:0]    sample,
    input  logic [2:0]       mode,
    input  logic [LOGW-1:0]  rpt_log2,
    input  logic             dbl_en,
    output logic [SW-1:0]    result,
    output logic [ACC_W-1:0] acc,
    output logic [CNT_W-1:0] cnt,
    output logic [SW-1:0]    filt,
    output logic             busy,
    output evt_t             evt
);
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0]    res_d, filt_d;
    logic [ACC_W-1:0] acc_d, base_a;
    logic [CNT_W-1:0] cnt_d, base_c, n_c;
    logic             busy_d, reseed_q, reseed_d, pair_q, pair_d, take, hit;
    evt_t             evt_d;
    logic signed [SW+1:0] diff, step, lsum;

    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                                 input logic [SW-1:0] x);
        logic [ACC_W:0] s;
        s = {1'b0, a} + {{(ACC_W-SW+1){1'b0}}, x};
        return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
    endfunction

    function automatic logic [SW-1:0] scale(input logic [ACC_W-1:0] a,
                                            input logic [LOGW-1:0] sh);
        logic [ACC_W-1:0] q;
        q = a >> sh;
        return (q > ACC_W'(SMAX)) ? SMAX : q[SW-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] inc_sat(input logic [CNT_W-1:0] c);
        return (&c) ? c : c + 1'b1;
    endfunction

    always_comb begin
        n_c      = CNT_W'(1) << rpt_log2;
        res_d    = result;
        acc_d    = acc;
        cnt_d    = cnt;
        filt_d   = filt;
        busy_d   = busy;
        reseed_d = reseed_q;
        pair_d   = pair_q;
        evt_d    = '0;
        base_a   = '0;
        base_c   = '0;
        hit      = 1'b0;
        diff     = $signed({2'b00, sample}) - $signed({2'b00, filt});
        step     = diff >>> rpt_log2;
        lsum     = $signed({2'b00, filt}) + step;
        take     = (mode == MD_BURST) ? (busy | trig) : trig;
        if (take) begin
            res_d      = sample;
            evt_d.conv = 1'b1;
            case (mode)
                MD_ACCUM: begin
                    acc_d      = sat_add(acc, sample);
                    cnt_d      = inc_sat(cnt);
                    filt_d     = scale(acc_d, rpt_log2);
                    evt_d.test = 1'b1;
                end
                MD_AVG: begin
                    base_a   = reseed_q ? '0 : acc;
                    base_c   = reseed_q ? '0 : cnt;
                    acc_d    = sat_add(base_a, sample);
                    cnt_d    = inc_sat(base_c);
                    hit      = cnt_d >= n_c;
                    reseed_d = hit;
                    if (hit) begin
                        filt_d     = scale(acc_d, rpt_log2);
                        evt_d.test = 1'b1;
                    end
                end
                MD_BURST: begin
                    base_a = busy ? acc : '0;
                    base_c = busy ? cnt : '0;
                    acc_d  = sat_add(base_a, sample);
                    cnt_d  = inc_sat(base_c);
                    hit    = cnt_d >= n_c;
                    busy_d = !hit;
                    if (hit) begin
                        filt_d     = scale(acc_d, rpt_log2);
                        evt_d.test = 1'b1;
                    end
                end
                MD_LPF: begin
                    filt_d     = lsum[SW-1:0];
                    cnt_d      = (cnt >= n_c) ? cnt : cnt + 1'b1;
                    evt_d.test = cnt_d >= n_c;
                end
                default: begin
                    filt_d     = sample;
                    evt_d.conv = dbl_en ? pair_q : 1'b1;
                    pair_d     = dbl_en ? !pair_q : 1'b0;
                    evt_d.test = evt_d.conv;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            acc      <= '0;
            cnt      <= '0;
            filt     <= '0;
            busy     <= 1'b0;
            reseed_q <= 1'b0;
            pair_q   <= 1'b0;
            evt      <= '0;
        end else begin
            result   <= res_d;
            acc      <= acc_d;
            cnt      <= cnt_d;
            filt     <= filt_d;
            busy     <= busy_d;
            reseed_q <= reseed_d;
            pair_q   <= pair_d;
            evt      <= evt_d;
        end
    end

endmodule

// File: rtl/adcpp_thresh.sv
module adcpp_thresh
    import adcpp_pkg::*;
#(
    parameter int SW = 10,
    parameter int EW = 12
) (
    input  logic [SW-1:0]        result,
    input  logic [SW-1:0]        filt,
    input  logic [SW-1:0]        prev,
    input  logic [SW-1:0]        setpoint,
    input  logic [2:0]           calc_sel,
    input  logic signed [EW-1:0] thr_lo,
    input  logic signed [EW-1:0] thr_hi,
    input  logic [2:0]           thr_mode,
    output logic signed [EW-1:0] err,
    output logic                 hit
);
    logic signed [EW-1:0] a, b, d;

    always_comb begin
        a   = $signed({{(EW-SW){1'b0}}, (calc_sel[0] ? filt : result)});
        b   = $signed({{(EW-SW){1'b0}}, (calc_sel[1] ? setpoint : prev)});
        d   = a - b;
        err = calc_sel[2] ? -d : d;
        hit = thr_hit(thr_mode, err < thr_lo, err > thr_hi);
    end

endmodule

// File: rtl/adcpp_engine.sv
module adcpp_engine
    import adcpp_pkg::*;
#(
    parameter int SW      = 10,
    parameter int LOG_MAX = 7,
    localparam int LOGW   = $clog2(LOG_MAX + 1),
    localparam int ACC_W  = SW + LOG_MAX + 1,
    localparam int CNT_W  = LOG_MAX + 1,
    localparam int EW     = SW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig,
    input  logic [SW-1:0]        sample,
    input  logic [2:0]           mode,
    input  logic [LOGW-1:0]      rpt_log2,
    input  logic                 dbl_en,
    input  logic [2:0]           calc_sel,
    input  logic                 prev_sel,
    input  logic [SW-1:0]        setpoint,
    input  logic signed [EW-1:0] thr_lo,
    input  logic signed [EW-1:0] thr_hi,
    input  logic [2:0]           thr_mode,
    input  logic                 flag_clr,
    output logic [SW-1:0]        result,
    output logic [ACC_W-1:0]     acc,
    output logic [CNT_W-1:0]     cnt,
    output logic [SW-1:0]        filt,
    output logic signed [EW-1:0] err,
    output logic                 busy,
    output logic                 conv_flag,
    output logic                 thr_flag
);
    evt_t                 evt;
    logic [SW-1:0]        prev_q;
    logic signed [EW-1:0] err_c;
    logic                 hit_c;

    adcpp_core #(
        .SW(SW), .LOG_MAX(LOG_MAX), .LOGW(LOGW), .ACC_W(ACC_W), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst(rst), .trig(trig), .sample(sample), .mode(mode),
        .rpt_log2(rpt_log2), .dbl_en(dbl_en), .result(result), .acc(acc),
        .cnt(cnt), .filt(filt), .busy(busy), .evt(evt)
    );

    adcpp_thresh #(.SW(SW), .EW(EW)) u_thr (
        .result(result), .filt(filt), .prev(prev_q), .setpoint(setpoint),
        .calc_sel(calc_sel), .thr_lo(thr_lo), .thr_hi(thr_hi),
        .thr_mode(thr_mode), .err(err_c), .hit(hit_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err       <= '0;
            prev_q    <= '0;
            conv_flag <= 1'b0;
            thr_flag  <= 1'b0;
        end else begin
            if (evt.test) begin
                err    <= err_c;
                prev_q <= prev_sel ? filt : result;
            end
            conv_flag <= evt.conv | (conv_flag & ~flag_clr);
            thr_flag  <= (evt.test & hit_c) | (thr_flag & ~flag_clr);
        end
    end

endmodule

// File: rtl/adcpp_chk.sv
module adcpp_chk
    import adcpp_pkg::*;
#(
    parameter int SW    = 10,
    parameter int ACC_W = 18,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             trig,
    input logic [2:0]       mode,
    input logic             flag_clr,
    input logic [SW-1:0]    result,
    input logic [ACC_W-1:0] acc,
    input logic [CNT_W-1:0] cnt,
    input logic             busy,
    input logic             conv_flag,
    input logic             thr_flag
);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!trig && !busy) |=> $stable(result));

    assert_acc_grows_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_ACCUM && trig) |=> (acc >= $past(acc)));

    assert_burst_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt == CNT_W'(1)));

    assert_burst_step_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && mode == MD_BURST) |=> (cnt == $past(cnt) + 1'b1));

    assert_conv_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (conv_flag && !flag_clr) |=> conv_flag);

    assert_thr_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (thr_flag && !flag_clr) |=> thr_flag);

endmodule

bind adcpp_engine adcpp_chk #(.SW(SW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .trig(trig), .mode(mode), .flag_clr(flag_clr),
    .result(result), .acc(acc), .cnt(cnt), .busy(busy),
    .conv_flag(conv_flag), .thr_flag(thr_flag)
);

// File: tb/tb_adcpp_engine.sv
module tb_adcpp_engine;
    localparam int SW = 10, LOG_MAX = 7, EW = 12;
    localparam int ACC_MAX = (1 << 18) - 1, CNT_MAX = 255, SMAX = 1023;

    logic clk = 0, rst = 1, trig = 0, dbl_en = 0, prev_sel = 0, flag_clr = 0;
    logic [SW-1:0] sample = '0, setpoint = '0;
    logic [2:0] mode = '0, calc_sel = '0, thr_mode = '0;
    logic [2:0] rpt_log2 = '0;
    logic signed [EW-1:0] thr_lo = '0, thr_hi = '0;
    logic [SW-1:0] result, filt;
    logic [17:0] acc;
    logic [7:0] cnt;
    logic signed [EW-1:0] err;
    logic busy, conv_flag, thr_flag;

    int checks = 0, errors = 0;
    // model state and next state
    int m_res, m_acc, m_cnt, m_filt, m_busy, m_reseed, m_pair, m_conv, m_test;
    int m_err, m_prev, m_cf, m_tf;
    int n_res, n_acc, n_cnt, n_filt, n_busy, n_reseed, n_pair, n_conv, n_test;
    int n_err, n_prev, n_cf, n_tf;

    adcpp_engine #(.SW(SW), .LOG_MAX(LOG_MAX)) dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic string mtag();
        case (mode)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R1";
        endcase
    endfunction

    function automatic int scale_m(input int a);
        int q = a >>> rpt_log2;
        return (q > SMAX) ? SMAX : q;
    endfunction

    function automatic int calc_m();
        int a = calc_sel[0] ? m_filt : m_res;
        int b = calc_sel[1] ? int'(setpoint) : m_prev;
        int d = a - b;
        return calc_sel[2] ? -d : d;
    endfunction

    function automatic int hit_m(input int e);
        int lo = thr_lo, hi = thr_hi;
        bit bl = e < lo, ab = e > hi;
        case (thr_mode)
            3'd0: return 0;
            3'd1: return bl;
            3'd2: return !bl;
            3'd3: return !bl && !ab;
            3'd4: return bl || ab;
            3'd5: return !ab;
            3'd6: return ab;
            default: return 1;
        endcase
    endfunction

    task automatic model_zero();
        m_res = 0; m_acc = 0; m_cnt = 0; m_filt = 0; m_busy = 0; m_reseed = 0;
        m_pair = 0; m_conv = 0; m_test = 0; m_err = 0; m_prev = 0; m_cf = 0; m_tf = 0;
    endtask

    task automatic model_next(input bit t, input int s, input bit c);
        int nn = 1 << rpt_log2;
        bit take = (mode == 3) ? (m_busy != 0 || t) : t;
        int e;
        n_err = m_err; n_prev = m_prev;
        e = calc_m();
        if (m_test != 0) begin
            n_err = e;
            n_prev = prev_sel ? m_filt : m_res;
        end
        n_cf = (m_conv != 0 || (m_cf != 0 && !c)) ? 1 : 0;
        n_tf = ((m_test != 0 && hit_m(e) != 0) || (m_tf != 0 && !c)) ? 1 : 0;
        n_res = m_res; n_acc = m_acc; n_cnt = m_cnt; n_filt = m_filt; n_busy = m_busy;
        n_reseed = m_reseed; n_pair = m_pair; n_conv = 0; n_test = 0;
        if (take) begin
            n_res = s; n_conv = 1;
            case (mode)
                3'd1: begin
                    n_acc = (m_acc + s > ACC_MAX) ? ACC_MAX : m_acc + s;
                    n_cnt = (m_cnt == CNT_MAX) ? m_cnt : m_cnt + 1;
                    n_filt = scale_m(n_acc); n_test = 1;
                end
                3'd2, 3'd3: begin
                    bit fresh = (mode == 2) ? (m_reseed != 0) : (m_busy == 0);
                    n_acc = (fresh ? 0 : m_acc) + s;
                    n_cnt = (fresh ? 0 : m_cnt) + 1;
                    if (mode == 2) n_reseed = (n_cnt >= nn);
                    else n_busy = (n_cnt < nn);
                    if (n_cnt >= nn) begin n_filt = scale_m(n_acc); n_test = 1; end
                end
                3'd4: begin
                    n_filt = m_filt + ((s - m_filt) >>> rpt_log2);
                    n_cnt = (m_cnt >= nn) ? m_cnt : m_cnt + 1;
                    n_test = (n_cnt >= nn);
                end
                default: begin
                    n_filt = s;
                    n_conv = dbl_en ? m_pair : 1;
                    n_pair = dbl_en ? (m_pair == 0) : 0;
                    n_test = n_conv;
                end
            endcase
        end
    endtask

    task automatic compare_all();
        string tg = mtag();
        check({tg, " result"}, int'(result), m_res);
        check({tg, " acc"}, int'(acc), m_acc);
        check({(mode == 2) ? "R4" : tg, " cnt"}, int'(cnt), m_cnt);
        check({tg, " filt"}, int'(filt), m_filt);
        check("R5 busy", int'(busy), m_busy);
        check("R7/R8 err", int'(err), m_err);
        check("R10 conv_flag", int'(conv_flag), m_cf);
        check("R9 thr_flag", int'(thr_flag), m_tf);
    endtask

    task automatic tick(input bit t, input int s, input bit c);
        trig = t; sample = SW'(s); flag_clr = c;
        model_next(t, s, c);
        @(posedge clk); #1;
        m_res = n_res; m_acc = n_acc; m_cnt = n_cnt; m_filt = n_filt; m_busy = n_busy;
        m_reseed = n_reseed; m_pair = n_pair; m_conv = n_conv; m_test = n_test;
        m_err = n_err; m_prev = n_prev; m_cf = n_cf; m_tf = n_tf;
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1; trig = 0; flag_clr = 0;
        repeat (2) @(posedge clk);
        #1; rst = 0; model_zero();
        check("R12 acc", int'(acc), 0);
        check("R12 cnt", int'(cnt), 0);
        check("R12 flags", int'({conv_flag, thr_flag, busy}), 0);
        check("R12 err", int'(err), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: average reseed, N=2
        mode = 3'd2; rpt_log2 = 3'd1; calc_sel = 3'd1; thr_mode = 3'd7;
        do_reset();
        tick(1, 10, 0); tick(1, 20, 0);
        check("R3 avg filt", int'(filt), 15);
        tick(1, 30, 0);
        check("R4 reseed acc", int'(acc), 30);
        check("R4 reseed cnt", int'(cnt), 1);
        tick(0, 0, 0);
        check("R9 thr always", int'(thr_flag), 1);
        // directed: burst with triggers while busy, N=4
        mode = 3'd3; rpt_log2 = 3'd2; do_reset();
        tick(1, 4, 0); tick(1, 8, 0); tick(1, 12, 0); tick(1, 16, 0);
        check("R5 burst filt", int'(filt), 10);
        check("R5 burst done", int'(busy), 0);
        // directed: basic paired triggers
        mode = 3'd0; dbl_en = 1; do_reset();
        tick(1, 5, 0); tick(0, 0, 0);
        check("R1 pair first", int'(conv_flag), 0);
        tick(1, 6, 0); tick(0, 0, 0);
        check("R1 pair second", int'(conv_flag), 1);
        dbl_en = 0;
        // directed: accumulator saturation
        mode = 3'd1; rpt_log2 = 3'd0; do_reset();
        for (int i = 0; i < 300; i++) tick(1, SMAX, 0);
        check("R11 acc saturated", int'(acc), ACC_MAX);
        check("R2 cnt saturated", int'(cnt), CNT_MAX);
        // random phases
        for (int ph = 0; ph < 50; ph++) begin
            int lo;
            mode = 3'(ph % 5);
            rpt_log2 = 3'($urandom % 8);
            dbl_en = $urandom % 2; prev_sel = $urandom % 2;
            calc_sel = 3'($urandom % 8); thr_mode = 3'($urandom % 8);
            setpoint = SW'($urandom % 1024);
            lo = int'($urandom % 1200) - 600;
            thr_lo = EW'(lo); thr_hi = EW'(lo + int'($urandom % 800));
            do_reset();
            for (int i = 0; i < 300; i++) begin
                bit t = (mode == 3) ? ($urandom % 4 == 0) : ($urandom % 2 == 0);
                int s = (i % 50 < 3) ? ((i % 2) ? SMAX : 0) : int'($urandom % 1024);
                tick(t, s, $urandom % 12 == 0);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule